// File: doc/BRIEF.md
# Memory Controller Configuration Register File

This block is the register bank that sets up an external memory controller. Software reaches it over a plain 32-bit word-addressed register bus with a request strobe, write enable, address and write data. Every access is accepted in the cycle it is presented. Read data and an error flag come back from a register one cycle later. The bus has no back-pressure: there is no ready signal, and a new request may follow in every cycle.

The bank holds four kinds of register. There is a general control word and a read-only view of a strapped power-on word. There is a base-address mask that keeps only a fixed set of valid bits. Each chip select also has a configuration and timing pair. At reset, chip select 0 is built from the power-on word: it gets a memory type, a bus width and a default timing, so a boot memory can be used before software writes anything.

A per-chip-select decode stage is fed continuously with the enable bit, the address compare field and the derived read and write delays of every chip select. It also receives a one-cycle update pulse for each chip select whose registers were just written.

Top module: `mcfg_regfile`

## Requirements
- R1: An access address is taken relative to the parameter `BASE_ADDR` (default 0x8000), and address bits [1:0] are ignored. An address below the base, or at or beyond offset 0x10 + 8*NUM_CS, is out of range.
- R2: The control word at offset 0x00 stores all 32 written bits and reads them back.
- R3: The power-on word at offset 0x04 always reads the `strap_i` value, and writes to it have no effect.
- R4: The base mask at offset 0x08 stores only the bits set in `BMASK_VALID` (default 0x000000FF), and reads as that masked value.
- R5: Chip select i has its configuration register at offset 0x10 + 8*i and its timing register at offset 0x14 + 8*i. Address bit 2 selects timing, and (offset - 0x10) >> 3 is the index.
- R6: Reset clears every register except chip select 0 configuration. That register is loaded with enable bit 0 = 1, width field [2:1] = strap[1:0] and type field [5:3] = {0, strap[3:2]}. The configuration layout is bit 0 enable, [2:1] width, [5:3] memory type (0 SDRAM, 1 burst SRAM, 2 asynchronous, 3 synchronous) and [23:16] address compare.
- R7: At reset, chip select 0 timing loads a default that depends on its type: 0x00000020 for SDRAM, 0x00000001 for burst SRAM, 0x00412306 for asynchronous and 0x00000002 for synchronous.
- R8: A write to a chip select's configuration or timing register raises bit i of `cs_upd_o` for exactly one cycle, in the cycle after the write. The decode outputs of that chip select show the new value in that same cycle.
- R9: The delays of a chip select are derived from its type and timing word t, as follows:
  - asynchronous: read = t[7:0] + t[11:8], write = t[15:12] + t[19:16] + t[25:20];
  - SDRAM: read = write = 3 + t[5:4];
  - burst SRAM and synchronous: read = write = 2;
  - types 4 to 7: read = write = 0.
- R10: An out-of-range access, including offset 0x0C, changes no register and reads zero. It raises `bus_err` for one cycle, in the cycle after the access.
- R11: Read data appears on `bus_rdata` in the cycle after the request. `bus_rdata` is zero after any cycle that was not an in-range read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 32 | Strapped power-on word |
| bus_req | input | 1 | Access request, accepted every cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Out-of-range access pulse |
| dec_en_o | output | NUM_CS | Chip select enable bits |
| dec_cmp_o | output | NUM_CS*8 | Address compare field per chip select |
| dec_mask_o | output | 8 | Low byte of the base mask |
| dec_rd_dly_o | output | NUM_CS*DLY_W | Read delay per chip select |
| dec_wr_dly_o | output | NUM_CS*DLY_W | Write delay per chip select |
| cs_upd_o | output | NUM_CS | One-cycle update pulse per chip select |

## Verification
The assertions assume that `strap_i` is stable while reset is asserted and for as long as the power-on word is read. They also assume that `bus_we` and `bus_addr` are meaningful only in cycles where `bus_req` is high. The stimulus sets the strap before each reset and leaves it unchanged until the next one. It drives the bus signals only at falling edges, and drops the request between accesses.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  typedef enum logic [2:0] {
    MT_SDRAM = 3'd0,
    MT_SSRAM = 3'd1,
    MT_ASYNC = 3'd2,
    MT_SYNC  = 3'd3
  } mem_type_e;

  typedef enum logic [2:0] {
    RK_CTRL, RK_POWERON, RK_BMASK, RK_CS, RK_NONE
  } reg_kind_e;

  localparam logic [31:0] TIM_DEF_SDRAM = 32'h0000_0020;
  localparam logic [31:0] TIM_DEF_SSRAM = 32'h0000_0001;
  localparam logic [31:0] TIM_DEF_ASYNC = 32'h0041_2306;
  localparam logic [31:0] TIM_DEF_SYNC  = 32'h0000_0002;

  function automatic logic [31:0] boot_cfg(input logic [31:0] strap);
    logic [31:0] c;
    c = 32'd0;
    c[0]   = 1'b1;
    c[2:1] = strap[1:0];
    c[5:3] = {1'b0, strap[3:2]};
    return c;
  endfunction

  function automatic logic [31:0] boot_tim(input logic [2:0] mt);
    case (mt)
      MT_SDRAM: return TIM_DEF_SDRAM;
      MT_SSRAM: return TIM_DEF_SSRAM;
      MT_ASYNC: return TIM_DEF_ASYNC;
      MT_SYNC:  return TIM_DEF_SYNC;
      default:  return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/mcfg_addr_dec.sv
module mcfg_addr_dec #(
  parameter int          NUM_CS    = 8,
  parameter logic [31:0] BASE_ADDR = 32'h0000_8000,
  localparam int         IDX_W     = $clog2(NUM_CS)
) (
  input  logic [31:0]          addr,
  output mcfg_pkg::reg_kind_e  kind,
  output logic [IDX_W-1:0]     cs_idx,
  output logic                 is_tim
);
  import mcfg_pkg::*;
  localparam logic [31:0] MAP_END = 32'h10 + 32'(8 * NUM_CS);

  logic [31:0] off;
  logic [31:0] cs_off;

  always_comb begin
    off    = {addr[31:2], 2'b00} - BASE_ADDR;
    cs_off = off - 32'h10;
    cs_idx = cs_off[IDX_W+2:3];
    is_tim = off[2];
    if (addr < BASE_ADDR || off >= MAP_END) kind = RK_NONE;
    else if (off == 32'h0)                  kind = RK_CTRL;
    else if (off == 32'h4)                  kind = RK_POWERON;
    else if (off == 32'h8)                  kind = RK_BMASK;
    else if (off >= 32'h10)                 kind = RK_CS;
    else                                    kind = RK_NONE;
  end
endmodule

// File: rtl/mcfg_cs_slot.sv
module mcfg_cs_slot #(
  parameter bit IS_BOOT = 1'b0,
  parameter int DLY_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      strap_i,
  input  logic             wr_cfg,
  input  logic             wr_tim,
  input  logic [31:0]      wdata,
  output logic [31:0]      cfg_o,
  output logic [31:0]      tim_o,
  output logic [DLY_W-1:0] rd_dly,
  output logic [DLY_W-1:0] wr_dly
);
  import mcfg_pkg::*;
  logic [31:0] cfg_q, tim_q;
  logic [31:0] cfg_rst, tim_rst;

  always_comb begin
    if (IS_BOOT) begin
      cfg_rst = boot_cfg(strap_i);
      tim_rst = boot_tim(cfg_rst[5:3]);
    end else begin
      cfg_rst = 32'd0;
      tim_rst = 32'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= cfg_rst;
      tim_q <= tim_rst;
    end else begin
      if (wr_cfg) cfg_q <= wdata;
      if (wr_tim) tim_q <= wdata;
    end
  end

  always_comb begin
    case (cfg_q[5:3])
      MT_ASYNC: begin
        rd_dly = DLY_W'(tim_q[7:0]) + DLY_W'(tim_q[11:8]);
        wr_dly = DLY_W'(tim_q[15:12]) + DLY_W'(tim_q[19:16]) + DLY_W'(tim_q[25:20]);
      end
      MT_SDRAM: begin
        rd_dly = DLY_W'(3) + DLY_W'(tim_q[5:4]);
        wr_dly = DLY_W'(3) + DLY_W'(tim_q[5:4]);
      end
      MT_SSRAM, MT_SYNC: begin
        rd_dly = DLY_W'(2);
        wr_dly = DLY_W'(2);
      end
      default: begin
        rd_dly = '0;
        wr_dly = '0;
      end
    endcase
  end

  assign cfg_o = cfg_q;
  assign tim_o = tim_q;

  // R9: types other than asynchronous have equal read and write delays
  assert_sym_dly_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[5:3] != MT_ASYNC) |-> (rd_dly == wr_dly));
  // R8: a written register holds the written word in the next cycle
  assert_cfg_load_R8: assert property (@(posedge clk) disable iff (rst)
    wr_cfg |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/mcfg_regfile.sv
module mcfg_regfile #(
  parameter int          NUM_CS      = 8,
  parameter int          DLY_W       = 10,
  parameter logic [31:0] BASE_ADDR   = 32'h0000_8000,
  parameter logic [31:0] BMASK_VALID = 32'h0000_00FF,
  localparam int         IDX_W       = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [31:0]             strap_i,
  input  logic                    bus_req,
  input  logic                    bus_we,
  input  logic [31:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  output logic [NUM_CS-1:0]       dec_en_o,
  output logic [NUM_CS*8-1:0]     dec_cmp_o,
  output logic [7:0]              dec_mask_o,
  output logic [NUM_CS*DLY_W-1:0] dec_rd_dly_o,
  output logic [NUM_CS*DLY_W-1:0] dec_wr_dly_o,
  output logic [NUM_CS-1:0]       cs_upd_o
);
  import mcfg_pkg::*;

  reg_kind_e        kind;
  logic [IDX_W-1:0] cs_idx;
  logic             is_tim;
  logic [31:0]      ctrl_q, bmask_q;
  logic [NUM_CS-1:0] wr_cfg, wr_tim, upd_q;
  logic [31:0]      cfg_w [NUM_CS];
  logic [31:0]      tim_w [NUM_CS];
  logic [31:0]      rd_mux;
  logic             wr_acc;

  mcfg_addr_dec #(.NUM_CS(NUM_CS), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .kind(kind), .cs_idx(cs_idx), .is_tim(is_tim)
  );

  assign wr_acc = bus_req && bus_we;

  always_comb begin
    wr_cfg = '0;
    wr_tim = '0;
    if (wr_acc && kind == RK_CS) begin
      if (is_tim) wr_tim[cs_idx] = 1'b1;
      else        wr_cfg[cs_idx] = 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    mcfg_cs_slot #(.IS_BOOT(i == 0), .DLY_W(DLY_W)) u_slot (
      .clk(clk), .rst(rst), .strap_i(strap_i),
      .wr_cfg(wr_cfg[i]), .wr_tim(wr_tim[i]), .wdata(bus_wdata),
      .cfg_o(cfg_w[i]), .tim_o(tim_w[i]),
      .rd_dly(dec_rd_dly_o[i*DLY_W +: DLY_W]),
      .wr_dly(dec_wr_dly_o[i*DLY_W +: DLY_W])
    );
    assign dec_en_o[i]        = cfg_w[i][0];
    assign dec_cmp_o[i*8 +: 8] = cfg_w[i][23:16];
  end

  always_comb begin
    case (kind)
      RK_CTRL:    rd_mux = ctrl_q;
      RK_POWERON: rd_mux = strap_i;
      RK_BMASK:   rd_mux = bmask_q;
      RK_CS:      rd_mux = is_tim ? tim_w[cs_idx] : cfg_w[cs_idx];
      default:    rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bmask_q   <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      upd_q     <= '0;
    end else begin
      if (wr_acc && kind == RK_CTRL)  ctrl_q  <= bus_wdata;
      if (wr_acc && kind == RK_BMASK) bmask_q <= bus_wdata & BMASK_VALID;
      bus_rdata <= (bus_req && !bus_we) ? rd_mux : 32'd0;
      bus_err   <= bus_req && (kind == RK_NONE);
      upd_q     <= wr_cfg | wr_tim;
    end
  end

  assign dec_mask_o = bmask_q[7:0];
  assign cs_upd_o   = upd_q;

  // R8: at most one chip select updated per cycle
  assert_upd_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_upd_o));
  // R8: an update pulse always follows a bus write
  assert_upd_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    (cs_upd_o != '0) |-> $past(bus_req && bus_we));
  // R10: an error response carries zero data
  assert_err_zero_R10: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == 32'd0));
  // R6: chip select 0 comes out of reset enabled
  assert_boot_en_R6: assert property (@(posedge clk)
    $fell(rst) |-> dec_en_o[0]);
  // R4: invalid mask bits never set
  assert_mask_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (bmask_q & ~BMASK_VALID) == 32'd0);
endmodule

// File: tb/tb_mcfg_regfile.sv
module tb_mcfg_regfile;
  localparam int NUM_CS = 8;
  localparam int DLY_W  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] strap_i = 32'h0000_0002;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [NUM_CS-1:0] dec_en_o, cs_upd_o;
  logic [NUM_CS*8-1:0] dec_cmp_o;
  logic [7:0] dec_mask_o;
  logic [NUM_CS*DLY_W-1:0] dec_rd_dly_o, dec_wr_dly_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mcfg_regfile dut (
    .clk(clk), .rst(rst), .strap_i(strap_i), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .dec_en_o(dec_en_o), .dec_cmp_o(dec_cmp_o),
    .dec_mask_o(dec_mask_o), .dec_rd_dly_o(dec_rd_dly_o),
    .dec_wr_dly_o(dec_wr_dly_o), .cs_upd_o(cs_upd_o)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h8000, 32'h0,         32'h0,         1'b0}, // R6 ctrl cleared
    '{1'b1, 32'h8000, 32'hDEADBEEF,  32'h0,         1'b0}, // R11 write gives zero
    '{1'b0, 32'h8000, 32'h0,         32'hDEADBEEF,  1'b0}, // R2
    '{1'b1, 32'h8004, 32'hFFFFFFFF,  32'h0,         1'b0}, // R3
    '{1'b0, 32'h8004, 32'h0,         32'h00000002,  1'b0}, // R3
    '{1'b1, 32'h8008, 32'h123456AB,  32'h0,         1'b0}, // R4
    '{1'b0, 32'h8008, 32'h0,         32'h000000AB,  1'b0}, // R4
    '{1'b0, 32'h8010, 32'h0,         32'h00000005,  1'b0}, // R6
    '{1'b0, 32'h8014, 32'h0,         32'h00000020,  1'b0}, // R7
    '{1'b1, 32'h802C, 32'h00000030,  32'h0,         1'b0}, // R5
    '{1'b0, 32'h802C, 32'h0,         32'h00000030,  1'b0}, // R5
    '{1'b0, 32'h8028, 32'h0,         32'h0,         1'b0}, // R5
    '{1'b1, 32'h8048, 32'h00AB0011,  32'h0,         1'b0}, // R5
    '{1'b0, 32'h8048, 32'h0,         32'h00AB0011,  1'b0}, // R5
    '{1'b0, 32'h800C, 32'h0,         32'h0,         1'b1}, // R10 hole
    '{1'b1, 32'h8050, 32'hFFFFFFFF,  32'h0,         1'b1}, // R10 past end
    '{1'b0, 32'h7FFC, 32'h0,         32'h0,         1'b1}, // R1 below base
    '{1'b0, 32'h804A, 32'h0,         32'h00AB0011,  1'b0}, // R1 low bits ignored
    '{1'b0, 32'h8000, 32'h0,         32'hDEADBEEF,  1'b0}  // R10 no effect
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_reset(input logic [31:0] s);
    @(negedge clk);
    strap_i = s; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(32'h0000_0002);
    check("R6 en0", 32'(dec_en_o), 32'h01);
    check("R9 sdram rd", 32'(dec_rd_dly_o[0 +: DLY_W]), 32'd5);
    check("R11 rdata idle", bus_rdata, 32'h0);
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, VEC[i].addr, VEC[i].wd);
      check($sformatf("vec%0d data", i), bus_rdata, VEC[i].exp);
      check($sformatf("vec%0d R10 err", i), 32'(bus_err), 32'(VEC[i].err));
    end
    @(negedge clk);
    check("R10 err one cycle", 32'(bus_err), 32'h0);
    check("R4 mask out", 32'(dec_mask_o), 32'hAB);

    access(1'b1, 32'h8028, 32'h0055_0011);
    check("R8 upd pulse", 32'(cs_upd_o), 32'h08);
    check("R8 en cs3", 32'(dec_en_o[3]), 32'h1);
    check("R8 cmp cs3", 32'(dec_cmp_o[3*8 +: 8]), 32'h55);
    check("R9 async rd", 32'(dec_rd_dly_o[3*DLY_W +: DLY_W]), 32'd48);
    @(negedge clk);
    check("R8 pulse ends", 32'(cs_upd_o), 32'h0);
    access(1'b1, 32'h802C, 32'h0051_3207);
    check("R8 tim upd", 32'(cs_upd_o), 32'h08);
    check("R9 async rd2", 32'(dec_rd_dly_o[3*DLY_W +: DLY_W]), 32'd9);
    check("R9 async wr2", 32'(dec_wr_dly_o[3*DLY_W +: DLY_W]), 32'd9);
    access(1'b1, 32'h8018, 32'h0000_0008);
    check("R9 ssram rd", 32'(dec_rd_dly_o[1*DLY_W +: DLY_W]), 32'd2);
    check("R9 ssram wr", 32'(dec_wr_dly_o[1*DLY_W +: DLY_W]), 32'd2);
    access(1'b1, 32'h8018, 32'h0000_0028);
    check("R9 type5 rd", 32'(dec_rd_dly_o[1*DLY_W +: DLY_W]), 32'd0);
    access(1'b1, 32'h8050, 32'h0000_0011);
    check("R10 no upd", 32'(cs_upd_o), 32'h0);

    do_reset(32'h0000_0009);
    access(1'b0, 32'h8010, 32'h0);
    check("R6 cs0 cfg async", bus_rdata, 32'h0000_0013);
    access(1'b0, 32'h8014, 32'h0);
    check("R7 cs0 tim async", bus_rdata, 32'h0041_2306);
    check("R9 boot async rd", 32'(dec_rd_dly_o[0 +: DLY_W]), 32'd9);
    check("R9 boot async wr", 32'(dec_wr_dly_o[0 +: DLY_W]), 32'd7);
    access(1'b0, 32'h8000, 32'h0);
    check("R6 ctrl cleared", bus_rdata, 32'h0);
    access(1'b0, 32'h8008, 32'h0);
    check("R6 mask cleared", bus_rdata, 32'h0);
    access(1'b0, 32'h8048, 32'h0);
    check("R6 cs7 cleared", bus_rdata, 32'h0);
    access(1'b0, 32'h8004, 32'h0);
    check("R3 strap view", bus_rdata, 32'h0000_0009);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule